// File: doc/BRIEF.md
# CPU Core Clock Speed Controller

This block sets the pace of a processor core. Three free-running source ticks arrive on one fast simulation clock: the main oscillator, a slow real-time oscillator and the PLL multiplier output. The block selects one of them and divides it by a programmable ratio from 1 to 128. The result is a single-cycle core clock enable. A timer enable runs beside it and carries every tick of the chosen source with no division. The speed setting also holds two bits that switch off the main oscillator and the PLL. The block drives both bits out to the analog side.

Software changes speed by writing a setting word. The period in progress still completes at the old ratio. The new setting, source included, is loaded only at the next core enable pulse, so no core period is ever cut short or stretched. A second register holds an interrupt-time setting. Interrupt entry swaps that setting in and saves the running one. Interrupt return puts the saved setting back. Nesting is not supported.

Setting word layout, with DIV_W = 7: bits [6:0] hold the divisor field N, which divides by N+1. Bits [8:7] select the source: 0 is the main oscillator, 1 the real-time oscillator, 2 the PLL and 3 is reserved. Bit 9 switches off the main oscillator. Bit 10 switches off the PLL.

Top module: `spd_ctl`

## Requirements
- R1: After reset the active setting is main oscillator, divisor field 0, both disable outputs low, sel_err low, in_isr low.
- R2: With divisor field N active, core_en is high on exactly every (N+1)-th tick of the active source, starting at the first tick after a reload.
- R3: timer_en is high on every tick of the active source whatever the divisor is.
- R4: Source code 0 selects osc_tick, 1 selects rtc_tick, 2 selects pll_tick. Code 3 is reserved and is rejected.
- R5: An accepted setting is loaded into act_src, act_div, osc_off and pll_off only in the cycle after a core_en pulse. The period running at the time of the write completes at the old divisor.
- R6: osc_off and pll_off show bits 9 and 10 of the active setting. The active source is never one whose own disable bit is set.
- R7: A setting write that selects code 3, the main oscillator with bit 9 set, or the PLL with bit 10 set is dropped and sets sel_err. Any accepted write to either setting register clears sel_err.
- R8: irq_enter outside an interrupt saves the requested setting, requests the interrupt setting and sets in_isr.
- R9: irq_return inside an interrupt requests the saved setting and clears in_isr. irq_return outside an interrupt has no effect.
- R10: irq_enter while in_isr is high changes neither the saved setting nor the requested one.
- R11: The interrupt setting is written through isr_we under the same rejection rule. An effective entry or return in the same cycle as spd_we drops that speed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast simulation clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Main oscillator tick |
| rtc_tick | input | 1 | Real-time oscillator tick |
| pll_tick | input | 1 | PLL output tick |
| spd_we | input | 1 | Speed setting write strobe |
| spd_wdata | input | DIV_W+4 | Speed setting word |
| isr_we | input | 1 | Interrupt setting write strobe |
| isr_wdata | input | DIV_W+4 | Interrupt setting word |
| irq_enter | input | 1 | Interrupt service entry pulse |
| irq_return | input | 1 | Interrupt service return pulse |
| core_en | output | 1 | Divided core clock enable |
| timer_en | output | 1 | Undivided timer clock enable |
| act_src | output | 2 | Active source code |
| act_div | output | DIV_W | Active divisor field |
| osc_off | output | 1 | Main oscillator disable |
| pll_off | output | 1 | PLL disable |
| sel_err | output | 1 | Last write was rejected |
| in_isr | output | 1 | Interrupt speed in force |

## Verification
The bench writes a new ratio in the same cycle as a pulse. A design that loaded the ratio at once would drop the pulse owed to the old period, or place it late. Divide-by-128 is timed end to end, which catches an off-by-one in the N+1 encoding. Writes that pick a switched-off source or the reserved code must leave the active source unchanged. If they did not, the core would stall on a dead tick. Double entry followed by return must restore the setting from before the first entry. A design that saved on every entry would return to the interrupt speed instead.

// File: rtl/spd_ctl.sv
module spd_ctl #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             rtc_tick,
  input  logic             pll_tick,
  input  logic             spd_we,
  input  logic [DIV_W+3:0] spd_wdata,
  input  logic             isr_we,
  input  logic [DIV_W+3:0] isr_wdata,
  input  logic             irq_enter,
  input  logic             irq_return,
  output logic             core_en,
  output logic             timer_en,
  output logic [1:0]       act_src,
  output logic [DIV_W-1:0] act_div,
  output logic             osc_off,
  output logic             pll_off,
  output logic             sel_err,
  output logic             in_isr
);
  localparam int SW     = DIV_W + 4;
  localparam int SRC_LO = DIV_W;
  localparam int OSC_B  = DIV_W + 2;
  localparam int PLL_B  = DIV_W + 3;

  logic [SW-1:0]    cfg_q, isr_q, save_q, act_q;
  logic [DIV_W-1:0] cnt_q;
  logic             in_q, err_q;

  function automatic logic bad_sel(input logic [SW-1:0] s);
    logic [1:0] src;
    src = s[SRC_LO+1:SRC_LO];
    return (src == 2'd3) || (src == 2'd0 && s[OSC_B]) || (src == 2'd2 && s[PLL_B]);
  endfunction

  logic tick, pulse, enter_go, ret_go, spd_go, any_wr;
  logic [1:0] a_src;

  assign a_src = act_q[SRC_LO+1:SRC_LO];
  always_comb begin
    case (a_src)
      2'd0:    tick = osc_tick;
      2'd1:    tick = rtc_tick;
      2'd2:    tick = pll_tick;
      default: tick = 1'b0;
    endcase
  end

  assign pulse    = tick && (cnt_q == '0);
  assign enter_go = irq_enter && !in_q;
  assign ret_go   = irq_return && in_q;
  assign spd_go   = spd_we && !enter_go && !ret_go;
  assign any_wr   = spd_go || isr_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == '0) begin
        act_q <= cfg_q;
        cnt_q <= cfg_q[DIV_W-1:0];
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      save_q <= '0;
      in_q   <= 1'b0;
    end else if (enter_go) begin
      save_q <= cfg_q;
      cfg_q  <= isr_q;
      in_q   <= 1'b1;
    end else if (ret_go) begin
      cfg_q  <= save_q;
      in_q   <= 1'b0;
    end else if (spd_go && !bad_sel(spd_wdata)) begin
      cfg_q  <= spd_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (isr_we && !bad_sel(isr_wdata)) isr_q <= isr_wdata;
      if (any_wr)
        err_q <= (spd_go && bad_sel(spd_wdata)) || (isr_we && bad_sel(isr_wdata));
    end
  end

  assign core_en  = pulse;
  assign timer_en = tick;
  assign act_src  = a_src;
  assign act_div  = act_q[DIV_W-1:0];
  assign osc_off  = act_q[OSC_B];
  assign pll_off  = act_q[PLL_B];
  assign sel_err  = err_q;
  assign in_isr   = in_q;

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_q[DIV_W-1:0]);

  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> $stable(act_q));

  // R6
  live_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((a_src == 2'd2 && pll_off) || (a_src == 2'd0 && osc_off) || a_src == 2'd3));

  // R7
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_we && !irq_enter && !irq_return && !isr_we && bad_sel(spd_wdata)) |=> sel_err);

  // R9
  stray_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_isr && irq_return && !irq_enter) |=> !in_isr);

  // R10
  no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_isr && irq_enter && !irq_return) |=> ($stable(save_q) && in_isr));
endmodule

// File: tb/sim_spd_ctl.sv
module sim_spd_ctl;
  localparam int DW = 7;
  localparam int SW = DW + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_t = 0, rtc_t = 0, pll_t = 0;
  logic spd_we = 0, isr_we = 0, irq_en = 0, irq_rt = 0;
  logic [SW-1:0] spd_d = '0, isr_d = '0;
  logic core_en, timer_en, osc_off, pll_off, sel_err, in_isr;
  logic [1:0] act_src;
  logic [DW-1:0] act_div;

  always #10 clk = ~clk;

  spd_ctl #(.DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_t), .rtc_tick(rtc_t), .pll_tick(pll_t),
    .spd_we(spd_we), .spd_wdata(spd_d), .isr_we(isr_we), .isr_wdata(isr_d),
    .irq_enter(irq_en), .irq_return(irq_rt), .core_en(core_en), .timer_en(timer_en),
    .act_src(act_src), .act_div(act_div), .osc_off(osc_off), .pll_off(pll_off),
    .sel_err(sel_err), .in_isr(in_isr));

  int checks = 0, errs = 0;
  bit done = 0;
  logic seen_core;

  logic [SW-1:0] m_cfg, m_isr, m_save, m_act;
  logic [DW-1:0] m_cnt;
  logic m_in, m_err;

  function automatic logic [SW-1:0] mk(logic poff, logic ooff, logic [1:0] s, logic [DW-1:0] d);
    return {poff, ooff, s, d};
  endfunction

  function automatic logic rejected(logic [SW-1:0] w);
    return (w[DW+1:DW] == 2'd3) || (w[DW+1:DW] == 2'd0 && w[DW+2]) ||
           (w[DW+1:DW] == 2'd2 && w[DW+3]);
  endfunction

  function automatic logic m_tick();
    case (m_act[DW+1:DW])
      2'd0: return osc_t;
      2'd1: return rtc_t;
      2'd2: return pll_t;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic t, e_go, r_go, s_go;
    t = m_tick();
    e_go = irq_en && !m_in;
    r_go = irq_rt && m_in;
    s_go = spd_we && !e_go && !r_go;
    if (t) begin
      if (m_cnt == 0) begin m_act = m_cfg; m_cnt = m_cfg[DW-1:0]; end
      else m_cnt = m_cnt - 1;
    end
    if (s_go || isr_we) m_err = (s_go && rejected(spd_d)) || (isr_we && rejected(isr_d));
    if (e_go) begin m_save = m_cfg; m_cfg = m_isr; m_in = 1; end
    else if (r_go) begin m_cfg = m_save; m_in = 0; end
    else if (s_go && !rejected(spd_d)) m_cfg = spd_d;
    if (isr_we && !rejected(isr_d)) m_isr = isr_d;
  endtask

  task automatic cyc();
    logic t;
    #1;
    t = m_tick();
    seen_core = core_en;
    check("R2 R5 core_en", {31'd0, core_en}, {31'd0, t && m_cnt == 0});
    check("R3 R4 timer_en", {31'd0, timer_en}, {31'd0, t});
    check("R5 R6 active setting", {21'd0, pll_off, osc_off, act_src, act_div},
          {21'd0, m_act});
    check("R7 R8 flags", {30'd0, sel_err, in_isr}, {30'd0, m_err, m_in});
    @(posedge clk);
    model_step();
    @(negedge clk);
    spd_we = 0; isr_we = 0; irq_en = 0; irq_rt = 0;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin cyc(); n++; end while (!seen_core && n < 400);
  endtask

  task automatic wr(logic [SW-1:0] w);
    spd_d = w; spd_we = 1; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    m_cfg = '0; m_isr = '0; m_save = '0; m_act = '0; m_cnt = '0; m_in = 0; m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 reset", {21'd0, pll_off, osc_off, act_src, act_div, sel_err, in_isr}, 32'd0);
    @(negedge clk);
    osc_t = 1; rtc_t = 1; pll_t = 1;
    repeat (3) cyc();
    check("R2 divide by one", {31'd0, seen_core}, 32'd1);

    // R5: the write cycle and the next one still pulse at the old ratio
    wr(mk(0, 0, 2'd0, 7'd127));
    check("R5 write cycle pulse", {31'd0, seen_core}, 32'd1);
    cyc();
    check("R5 old period completes", {31'd0, seen_core}, 32'd1);
    wait_pulse(n);
    // R2 field 127 divides by 128
    check("R2 divide by 128", n, 128);
    wait_pulse(n);
    check("R2 divide by 128 again", n, 128);

    // R4 R7 reserved source code rejected
    wr(mk(0, 0, 2'd3, 7'd0));
    check("R7 reserved flagged", {31'd0, sel_err}, 32'd1);
    wait_pulse(n);
    cyc();
    check("R4 reserved keeps source", {30'd0, act_src}, 32'd0);
    // R7 PLL with its disable bit set
    wr(mk(1, 0, 2'd2, 7'd1));
    check("R7 dead pll flagged", {31'd0, sel_err}, 32'd1);
    // R7 main oscillator with its disable bit set
    wr(mk(0, 1, 2'd0, 7'd1));
    check("R7 dead osc flagged", {31'd0, sel_err}, 32'd1);
    // R6 valid: run from RTC, switch off osc and pll
    wr(mk(1, 1, 2'd1, 7'd2));
    check("R7 accepted clears", {31'd0, sel_err}, 32'd0);
    wait_pulse(n);
    cyc();
    check("R6 disable outputs", {30'd0, pll_off, osc_off}, 32'd3);
    check("R4 rtc selected", {30'd0, act_src}, 32'd1);

    // R11 interrupt setting, R8 entry
    isr_d = mk(0, 0, 2'd2, 7'd0); isr_we = 1; cyc();
    irq_en = 1; cyc();
    check("R8 entry flag", {31'd0, in_isr}, 32'd1);
    wait_pulse(n); cyc();
    check("R8 interrupt speed", {30'd0, act_src}, 32'd2);
    // R10 second entry after changing the interrupt setting
    isr_d = mk(0, 0, 2'd0, 7'd5); isr_we = 1; cyc();
    irq_en = 1; cyc();
    wait_pulse(n); cyc();
    check("R10 nested ignored", {30'd0, act_src}, 32'd2);
    // R11 speed write dropped by return in the same cycle
    spd_d = mk(0, 0, 2'd0, 7'd9); spd_we = 1; irq_rt = 1; cyc();
    check("R9 return flag", {31'd0, in_isr}, 32'd0);
    wait_pulse(n); cyc();
    check("R9 restored", {30'd0, act_src}, 32'd1);
    check("R11 write dropped", {25'd0, act_div}, 32'd2);
    // R9 stray return
    irq_rt = 1; cyc();
    check("R9 stray return", {31'd0, in_isr}, 32'd0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      osc_t = ($urandom % 2) == 0;
      rtc_t = ($urandom % 5) == 0;
      pll_t = ($urandom % 4) != 0;
      if ($urandom % 25 == 0) begin
        spd_we = 1;
        spd_d = mk(($urandom % 4) == 0, ($urandom % 4) == 0, 2'($urandom),
                   ($urandom % 8 == 0) ? 7'($urandom) : 7'($urandom % 4));
      end
      if ($urandom % 60 == 0) begin
        isr_we = 1;
        isr_d = mk(($urandom % 4) == 0, ($urandom % 4) == 0, 2'($urandom), 7'($urandom % 4));
      end
      irq_en = ($urandom % 70) == 0;
      irq_rt = ($urandom % 70) == 0;
      cyc();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule